// File: doc/BRIEF.md
# DMA Channel Completion and Error Interrupt Unit

This unit keeps the interrupt state of a single DMA channel. The channel's transfer engine feeds it one-cycle pulses when a block finishes, when a whole transaction finishes, and when a transfer error occurs. It also feeds a level that says whether the channel runs in unlimited-repeat mode. From these inputs the unit keeps two sticky flags, one for transaction completion and one for errors. Each event also has a 2-bit interrupt level that software programs. The unit raises one leveled request per event and presents the level next to it.

Both requests go to the same interrupt vector, so the handler has to read the flags to learn which event fired. For that reason, taking the interrupt never clears a flag. Software clears a flag only by writing a one to its bit through the register write port. The same write also loads the two level fields. The full register is presented on a read-view output.

Register layout of `csr_q`: bit 5 is the error flag, bit 4 is the transaction flag, bits 3:2 are the error level and bits 1:0 are the transaction level. Bits 7:6 always read as zero.

Top module: `dma_chan_irq`

## Requirements
- R1: While `rst` is high at a clock edge, both flags and both level fields go to zero. After that edge `csr_q` reads 0x00, both requests are low and both level outputs read 0.
- R2: With `rpt_unlim` low, a `trn_done` pulse sets the transaction flag (bit 4) at the next edge. A `blk_done` pulse alone leaves the flag unchanged.
- R3: With `rpt_unlim` high, every `blk_done` pulse sets the transaction flag at the next edge.
- R4: A one-cycle `err_pulse` sets the error flag (bit 5) at the next edge. The flag stays set until software clears it.
- R5: A write (`wr_en` high) with a one in bit 4 or bit 5 of `wr_data` clears that flag at the next edge. A zero in either bit leaves the flag as it was.
- R6: No flag clears by itself. While no clear write is made, a set flag and its active request stay high for any number of cycles.
- R7: A write loads `wr_data[3:2]` into the error level and `wr_data[1:0]` into the transaction level. The levels hold when there is no write. Bits 7:6 of `csr_q` read zero whatever is written.
- R8: A level of 0 keeps that event's request low. The flag is still set by its event, and the request appears as soon as a nonzero level is written.
- R9: If a set event and a write-one clear of the same flag occur in the same cycle, the flag ends set.
- R10: Each request equals its flag AND (level != 0). Each level output equals the programmed level while its request is high, and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| blk_done | input | 1 | One-cycle pulse: a block transfer ended |
| trn_done | input | 1 | One-cycle pulse: the transaction ended |
| err_pulse | input | 1 | One-cycle pulse: a transfer error occurred |
| rpt_unlim | input | 1 | High while unlimited repeat is enabled |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data (flag clears and level fields) |
| csr_q | output | 8 | Read view of flags and level fields |
| trn_irq | output | 1 | Transaction-complete interrupt request |
| trn_irq_lvl | output | 2 | Level of the transaction request, 0 when idle |
| err_irq | output | 1 | Error interrupt request |
| err_irq_lvl | output | 2 | Level of the error request, 0 when idle |

## Verification
The bench builds the unit with its default parameters: a 2-bit level width, an 8-bit register, the transaction flag at bit 4 and the error flag at bit 5. With these values every level code from 0 to 3 can be reached. It also lets the bench hit both flags at once, collide a set with a clear in the same cycle, and write ones into the unused top bits. The vector walk switches between repeat and non-repeat mode. It includes writes that carry zero in the flag bits, and it checks that requests stay up during idle stretches.

// File: rtl/dmaint_pkg.sv
package dmaint_pkg;

    localparam int LVL_W     = 2;
    localparam int CSR_W     = 8;
    localparam int N_EVT     = 2;
    localparam int EV_TRN    = 0;
    localparam int EV_ERR    = 1;
    localparam int TRN_FLAG_BIT = 4;
    localparam int ERR_FLAG_BIT = 5;
    localparam int TRN_LVL_LSB  = 0;
    localparam int ERR_LVL_LSB  = 2;

    typedef logic [LVL_W-1:0] lvl_t;

    typedef struct packed {
        logic blk;
        logic trn;
        logic err;
    } evt_t;

    typedef struct packed {
        lvl_t err_lvl;
        lvl_t trn_lvl;
    } lvl_cfg_t;

    typedef struct packed {
        logic req;
        lvl_t lvl;
    } irq_t;

    function automatic logic lvl_enabled(lvl_t l);
        return l != '0;
    endfunction

    function automatic irq_t make_irq(logic flag, lvl_t l);
        irq_t r;
        r.req = flag && lvl_enabled(l);
        r.lvl = r.req ? l : '0;
        return r;
    endfunction

    function automatic logic [CSR_W-1:0] pack_csr(logic [N_EVT-1:0] flags, lvl_cfg_t c);
        logic [CSR_W-1:0] v;
        v = '0;
        v[TRN_FLAG_BIT] = flags[EV_TRN];
        v[ERR_FLAG_BIT] = flags[EV_ERR];
        v[TRN_LVL_LSB +: LVL_W] = c.trn_lvl;
        v[ERR_LVL_LSB +: LVL_W] = c.err_lvl;
        return v;
    endfunction

endpackage

// File: rtl/dmaint_evt_decode.sv
module dmaint_evt_decode
    import dmaint_pkg::*;
(
    input  evt_t                  evt_i,
    input  logic                  rpt_unlim_i,
    input  logic                  wr_en_i,
    input  logic [CSR_W-1:0]      wr_data_i,
    output logic [N_EVT-1:0]      set_o,
    output logic [N_EVT-1:0]      clr_o,
    output logic                  lvl_we_o,
    output lvl_cfg_t              lvl_wdata_o
);

    always_comb begin
        set_o          = '0;
        set_o[EV_TRN]  = evt_i.trn || (rpt_unlim_i && evt_i.blk);
        set_o[EV_ERR]  = evt_i.err;

        clr_o          = '0;
        clr_o[EV_TRN]  = wr_en_i && wr_data_i[TRN_FLAG_BIT];
        clr_o[EV_ERR]  = wr_en_i && wr_data_i[ERR_FLAG_BIT];

        lvl_we_o             = wr_en_i;
        lvl_wdata_o.trn_lvl  = wr_data_i[TRN_LVL_LSB +: LVL_W];
        lvl_wdata_o.err_lvl  = wr_data_i[ERR_LVL_LSB +: LVL_W];
    end

endmodule

// File: rtl/dmaint_flag.sv
module dmaint_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q_o
);

    always_ff @(posedge clk) begin
        if (rst)
            q_o <= 1'b0;
        else if (set_i)
            q_o <= 1'b1;
        else if (clr_i)
            q_o <= 1'b0;
    end

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst) set_i |=> q_o); // R9
    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst) (clr_i && !set_i) |=> !q_o); // R5
    AST_NO_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst) (!set_i && !clr_i) |=> (q_o == $past(q_o))); // R6

endmodule

// File: rtl/dmaint_lvl_reg.sv
module dmaint_lvl_reg
    import dmaint_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     we_i,
    input  lvl_cfg_t wdata_i,
    output lvl_cfg_t cfg_o
);

    always_ff @(posedge clk) begin
        if (rst)
            cfg_o <= '0;
        else if (we_i)
            cfg_o <= wdata_i;
    end

    AST_LVL_HOLD: assert property (@(posedge clk) disable iff (rst) !we_i |=> $stable(cfg_o)); // R7

endmodule

// File: rtl/dmaint_irq_out.sv
module dmaint_irq_out
    import dmaint_pkg::*;
(
    input  logic [N_EVT-1:0] flags_i,
    input  lvl_cfg_t         cfg_i,
    output irq_t             trn_irq_o,
    output irq_t             err_irq_o
);

    always_comb begin
        trn_irq_o = make_irq(flags_i[EV_TRN], cfg_i.trn_lvl);
        err_irq_o = make_irq(flags_i[EV_ERR], cfg_i.err_lvl);
    end

endmodule

// File: rtl/dma_chan_irq.sv
module dma_chan_irq
    import dmaint_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             blk_done,
    input  logic             trn_done,
    input  logic             err_pulse,
    input  logic             rpt_unlim,
    input  logic             wr_en,
    input  logic [CSR_W-1:0] wr_data,
    output logic [CSR_W-1:0] csr_q,
    output logic             trn_irq,
    output logic [LVL_W-1:0] trn_irq_lvl,
    output logic             err_irq,
    output logic [LVL_W-1:0] err_irq_lvl
);

    evt_t             evt;
    logic [N_EVT-1:0] set_v;
    logic [N_EVT-1:0] clr_v;
    logic [N_EVT-1:0] flags;
    logic             lvl_we;
    lvl_cfg_t         lvl_wdata;
    lvl_cfg_t         cfg;
    irq_t             trn_req;
    irq_t             err_req;

    assign evt.blk = blk_done;
    assign evt.trn = trn_done;
    assign evt.err = err_pulse;

    dmaint_evt_decode u_dec (
        .evt_i       (evt),
        .rpt_unlim_i (rpt_unlim),
        .wr_en_i     (wr_en),
        .wr_data_i   (wr_data),
        .set_o       (set_v),
        .clr_o       (clr_v),
        .lvl_we_o    (lvl_we),
        .lvl_wdata_o (lvl_wdata)
    );

    for (genvar g = 0; g < N_EVT; g++) begin : g_flag
        dmaint_flag u_flag (
            .clk   (clk),
            .rst   (rst),
            .set_i (set_v[g]),
            .clr_i (clr_v[g]),
            .q_o   (flags[g])
        );
    end

    dmaint_lvl_reg u_lvl (
        .clk     (clk),
        .rst     (rst),
        .we_i    (lvl_we),
        .wdata_i (lvl_wdata),
        .cfg_o   (cfg)
    );

    dmaint_irq_out u_irq (
        .flags_i   (flags),
        .cfg_i     (cfg),
        .trn_irq_o (trn_req),
        .err_irq_o (err_req)
    );

    assign csr_q       = pack_csr(flags, cfg);
    assign trn_irq     = trn_req.req;
    assign trn_irq_lvl = trn_req.lvl;
    assign err_irq     = err_req.req;
    assign err_irq_lvl = err_req.lvl;

    AST_RPT_BLOCK_SETS: assert property (@(posedge clk) disable iff (rst) (blk_done && rpt_unlim) |=> csr_q[TRN_FLAG_BIT]); // R3
    AST_TRN_FLAG_CAUSE: assert property (@(posedge clk) disable iff (rst) $rose(csr_q[TRN_FLAG_BIT]) |-> $past(trn_done || (blk_done && rpt_unlim))); // R2
    AST_ERR_SETS: assert property (@(posedge clk) disable iff (rst) err_pulse |=> csr_q[ERR_FLAG_BIT]); // R4
    AST_LVL0_QUIET: assert property (@(posedge clk) disable iff (rst) (csr_q[TRN_LVL_LSB +: LVL_W] == '0) |-> !trn_irq); // R8
    AST_IRQ_LVL_IDLE: assert property (@(posedge clk) disable iff (rst) !err_irq |-> (err_irq_lvl == '0)); // R10

endmodule

// File: tb/dma_chan_irq_tb.sv
module dma_chan_irq_tb;

    localparam int NV = 18;
    // {wr_en, wr_data[7:0], blk, trn, err, rpt, exp_trn_irq, exp_err_irq, exp_csr[7:0]}
    localparam logic [22:0] VEC [NV] = '{
        {1'b0, 8'h00, 4'b0000, 2'b00, 8'h00}, // R1 idle after reset
        {1'b1, 8'h05, 4'b0000, 2'b00, 8'h05}, // R7 load levels
        {1'b0, 8'h00, 4'b1000, 2'b00, 8'h05}, // R2 block alone, no repeat
        {1'b0, 8'h00, 4'b0100, 2'b10, 8'h15}, // R2 transaction done
        {1'b0, 8'h00, 4'b0000, 2'b10, 8'h15}, // R6 held
        {1'b1, 8'h05, 4'b0000, 2'b10, 8'h15}, // R5 write zero to flag
        {1'b1, 8'h15, 4'b0000, 2'b00, 8'h05}, // R5 write one clears
        {1'b0, 8'h00, 4'b1001, 2'b10, 8'h15}, // R3 block in repeat
        {1'b1, 8'h15, 4'b0000, 2'b00, 8'h05}, // R5 clear
        {1'b0, 8'h00, 4'b0010, 2'b01, 8'h25}, // R4 error pulse
        {1'b1, 8'h00, 4'b0000, 2'b00, 8'h20}, // R8 level 0 hides request
        {1'b1, 8'h0C, 4'b0000, 2'b01, 8'h2C}, // R8 request returns
        {1'b1, 8'h2C, 4'b0010, 2'b01, 8'h2C}, // R9 set beats clear
        {1'b1, 8'h2C, 4'b0000, 2'b00, 8'h0C}, // R5 clear error
        {1'b1, 8'h10, 4'b1001, 2'b00, 8'h10}, // R9 repeat set beats clear
        {1'b1, 8'h13, 4'b0000, 2'b00, 8'h03}, // R5 clear trn
        {1'b0, 8'h00, 4'b0110, 2'b10, 8'h33}, // R10 both events
        {1'b1, 8'h3B, 4'b0000, 2'b00, 8'h0B}  // R5 clear both
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       blk_done = 1'b0, trn_done = 1'b0, err_pulse = 1'b0, rpt_unlim = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] csr_q;
    logic       trn_irq, err_irq;
    logic [1:0] trn_irq_lvl, err_irq_lvl;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5ns clk = ~clk;

    dma_chan_irq u_dut (
        .clk(clk), .rst(rst), .blk_done(blk_done), .trn_done(trn_done),
        .err_pulse(err_pulse), .rpt_unlim(rpt_unlim), .wr_en(wr_en), .wr_data(wr_data),
        .csr_q(csr_q), .trn_irq(trn_irq), .trn_irq_lvl(trn_irq_lvl),
        .err_irq(err_irq), .err_irq_lvl(err_irq_lvl)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic w, input logic [7:0] d, input logic b, input logic t,
                         input logic e, input logic r);
        @(negedge clk);
        wr_en = w; wr_data = d; blk_done = b; trn_done = t; err_pulse = e; rpt_unlim = r;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00; blk_done = 1'b0; trn_done = 1'b0; err_pulse = 1'b0;
    endtask

    initial begin
        #1ms;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        chk("R1 csr", csr_q, 8'h00);
        chk("R1 irqs", {trn_irq, err_irq, trn_irq_lvl, err_irq_lvl}, 6'h00);

        for (int i = 0; i < NV; i++) begin
            logic [22:0] v;
            v = VEC[i];
            drive(v[22], v[21:14], v[13], v[12], v[11], v[10]);
            chk($sformatf("vector %0d csr", i), csr_q, v[7:0]);
            chk($sformatf("vector %0d irqs", i), {trn_irq, err_irq}, v[9:8]);
        end

        // R7 upper bits read zero
        drive(1'b1, 8'hC5, 0, 0, 0, 0);
        chk("R7 top bits", csr_q, 8'h05);

        // R10 level outputs follow programmed level only while requesting
        drive(1'b1, 8'h0B, 0, 0, 0, 0);
        chk("R10 idle lvls", {trn_irq_lvl, err_irq_lvl}, 4'h0);
        drive(1'b0, 8'h00, 0, 1, 0, 0);
        chk("R10 trn lvl", {trn_irq_lvl, err_irq_lvl}, {2'd3, 2'd0});
        drive(1'b0, 8'h00, 0, 0, 1, 0);
        chk("R10 err lvl", {trn_irq_lvl, err_irq_lvl}, {2'd3, 2'd2});

        // R6 requests persist over a long idle stretch
        repeat (20) @(negedge clk);
        chk("R6 held", {trn_irq, err_irq, csr_q}, {2'b11, 8'h3B});

        // R1 reset mid-run
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        chk("R1 reset again", {trn_irq, err_irq, trn_irq_lvl, err_irq_lvl, csr_q}, 14'h0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule